// File: doc/BRIEF.md
# Write-Completion Poller

This block sits on the host side of a parallel nonvolatile memory that programs itself after a write. It takes one command carrying a target address, a data byte and a polling method. It writes that byte over a simple synchronous request/acknowledge bus. It then finds out when the memory's internal programming has finished by reading the memory back, so it does not have to sit out the worst-case programming time.

Two detection methods are offered, and each command picks one. The bit-compare method keeps the written byte and compares status bit 7 of each read with bit 7 of that byte: while programming runs the memory returns that bit inverted. Once the bits agree, one more read checks the whole byte. The toggle method needs nothing saved. While programming runs the memory flips bit 6 on every read, so two back-to-back reads with equal bit 6 mean it has finished. After every outcome the block holds off new commands for a programmable settling window. A poll limit turns a memory that never finishes into a timeout result.

Top module: `pdp_poller`

## Requirements
- R1: After reset `cmd_ready_o` is 1, `bus_req_o` is 0 and `fin_o` is 0.
- R2: An accepted command produces exactly one bus write, carrying the command's address and data, before any read is issued.
- R3: In bit-compare mode (`cmd_mode_i`=0) every poll reads the command's address. A read whose bit 7 differs from bit 7 of the written byte leads to another poll.
- R4: In bit-compare mode, the first poll whose bit 7 matches is followed by exactly one confirm read. `fin_code_o` is 0 (success) when that read equals the whole written byte, and 1 (verify error) when it does not.
- R5: In toggle mode (`cmd_mode_i`=1) completion, with `fin_code_o`=0, is reported at the first poll whose bit 6 equals bit 6 of the poll just before it. The first poll after the write never completes, whatever its value.
- R6: If MAX_POLLS polls go by without completion, the block reports `fin_code_o`=2 (timeout) and issues no further read. A bit-7 match on the last allowed poll still leads to the confirm read.
- R7: `fin_o` is high for exactly one cycle per command. `cmd_ready_o` stays low from that cycle for GAP_CYCLES cycles and rises on the next one.
- R8: A bus request keeps address, direction and write data stable until acknowledged, and is dropped in the cycle after its acknowledge.
- R9: A command presented while `cmd_ready_o` is low is ignored: it causes no bus traffic and changes no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command accepted when valid |
| cmd_mode_i | input | 1 | 0 = bit-compare polling, 1 = toggle polling |
| cmd_addr_i | input | AW | Address to write and poll |
| cmd_data_i | input | DW | Byte to write |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Bus write data |
| bus_ack_i | input | 1 | Transaction complete, read data valid |
| bus_rdata_i | input | DW | Read data |
| fin_o | output | 1 | One-cycle completion strobe |
| fin_code_o | output | 2 | 0 success, 1 verify error, 2 timeout |

## Verification
The sweeps push the busy interval from zero polls up to past the poll limit. That exposes an off-by-one in the limit: a design with one would time out a write that finished on the last allowed poll, or allow one read too many. In toggle mode the starting phase of bit 6 is swept against the final bit 6 of the byte. This catches a design that assumes a starting value, which would declare completion on the very first read or one read late. In bit-compare mode, bytes whose low bit goes bad after programming catch a design that skips the confirm read or judges it on bit 7 alone. Commands pushed during the hold-off window catch a design that reopens early, which would issue a second write.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WRITE = 3'd1,
      ST_POLL  = 3'd2,
      ST_CONF  = 3'd3,
      ST_GAP   = 3'd4
   } pdp_state_e;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_VERIFY  = 2'd1,
      RES_TIMEOUT = 2'd2
   } pdp_res_e;

   localparam logic MODE_DATA   = 1'b0;
   localparam logic MODE_TOGGLE = 1'b1;

endpackage

// File: rtl/pdp_limit_cnt.sv
module pdp_limit_cnt #(
   parameter int LIMIT = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic inc_i,
   output logic at_last_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign at_last_o = (cnt_q == LAST);
endmodule

// File: rtl/pdp_judge.sv
module pdp_judge #(
   parameter int DW     = 8,
   parameter int DP_BIT = 7,
   parameter int TG_BIT = 6
) (
   input  logic [DW-1:0] rdata_i,
   input  logic [DW-1:0] sav_data_i,
   input  logic          prev_tg_i,
   input  logic          have_prev_i,
   output logic          dp_hit_o,
   output logic          tg_hit_o,
   output logic          byte_ok_o
);
   logic [DW-1:0] same;

   for (genvar b = 0; b < DW; b++) begin : g_bit
      assign same[b] = ~(rdata_i[b] ^ sav_data_i[b]);
   end

   assign dp_hit_o  = same[DP_BIT];
   assign tg_hit_o  = have_prev_i && (rdata_i[TG_BIT] == prev_tg_i);
   assign byte_ok_o = &same;
endmodule

// File: rtl/pdp_seq.sv
module pdp_seq
   import pdp_pkg::*;
#(
   parameter int AW = 15,
   parameter int DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cmd_valid_i,
   input  logic          cmd_mode_i,
   input  logic [AW-1:0] cmd_addr_i,
   input  logic [DW-1:0] cmd_data_i,
   output logic          cmd_ready_o,
   output logic          bus_req_o,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   input  logic          bus_ack_i,
   input  logic          rd_tg_i,
   input  logic          dp_hit_i,
   input  logic          tg_hit_i,
   input  logic          byte_ok_i,
   output logic [DW-1:0] sav_data_o,
   output logic          prev_tg_o,
   output logic          have_prev_o,
   input  logic          poll_last_i,
   output logic          poll_clr_o,
   output logic          poll_inc_o,
   input  logic          gap_last_i,
   output logic          gap_clr_o,
   output logic          gap_inc_o,
   output logic          fin_o,
   output logic [1:0]    fin_code_o
);
   pdp_state_e    st_q, st_n;
   pdp_res_e      res_q, res_n;
   logic          fin_q, fin_n;
   logic          req_q, we_q, mode_q, prev_q, have_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          take;

   assign take = req_q && bus_ack_i;

   always_comb begin
      st_n  = st_q;
      fin_n = 1'b0;
      res_n = RES_OK;
      case (st_q)
         ST_IDLE:  if (cmd_valid_i) st_n = ST_WRITE;
         ST_WRITE: if (take) st_n = ST_POLL;
         ST_POLL: if (take) begin
            if (mode_q == MODE_DATA) begin
               if (dp_hit_i) begin
                  st_n = ST_CONF;
               end else if (poll_last_i) begin
                  st_n = ST_GAP; fin_n = 1'b1; res_n = RES_TIMEOUT;
               end
            end else begin
               if (tg_hit_i) begin
                  st_n = ST_GAP; fin_n = 1'b1; res_n = RES_OK;
               end else if (poll_last_i) begin
                  st_n = ST_GAP; fin_n = 1'b1; res_n = RES_TIMEOUT;
               end
            end
         end
         ST_CONF: if (take) begin
            st_n  = ST_GAP;
            fin_n = 1'b1;
            res_n = byte_ok_i ? RES_OK : RES_VERIFY;
         end
         ST_GAP:  if (gap_last_i) st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         res_q  <= RES_OK;
         fin_q  <= 1'b0;
         req_q  <= 1'b0;
         we_q   <= 1'b0;
         mode_q <= MODE_DATA;
         prev_q <= 1'b0;
         have_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         st_q  <= st_n;
         fin_q <= fin_n;
         if (fin_n) res_q <= res_n;
         if (st_q == ST_IDLE && cmd_valid_i) begin
            req_q  <= 1'b1;
            we_q   <= 1'b1;
            mode_q <= cmd_mode_i;
            addr_q <= cmd_addr_i;
            data_q <= cmd_data_i;
            have_q <= 1'b0;
         end else if (take) begin
            req_q <= 1'b0;
            we_q  <= 1'b0;
            if (st_q == ST_POLL && mode_q == MODE_TOGGLE) begin
               prev_q <= rd_tg_i;
               have_q <= 1'b1;
            end
         end else if ((st_q == ST_POLL || st_q == ST_CONF) && !req_q) begin
            req_q <= 1'b1;
         end
      end
   end

   assign cmd_ready_o = (st_q == ST_IDLE);
   assign bus_req_o   = req_q;
   assign bus_we_o    = we_q;
   assign bus_addr_o  = addr_q;
   assign bus_wdata_o = data_q;
   assign sav_data_o  = data_q;
   assign prev_tg_o   = prev_q;
   assign have_prev_o = have_q;
   assign poll_clr_o  = (st_q == ST_IDLE);
   assign poll_inc_o  = take && (st_q == ST_POLL);
   assign gap_clr_o   = (st_q != ST_GAP);
   assign gap_inc_o   = (st_q == ST_GAP);
   assign fin_o       = fin_q;
   assign fin_code_o  = res_q;
endmodule

// File: rtl/pdp_poller.sv
module pdp_poller #(
   parameter int AW         = 15,
   parameter int DW         = 8,
   parameter int DP_BIT     = 7,
   parameter int TG_BIT     = 6,
   parameter int MAX_POLLS  = 4096,
   parameter int GAP_CYCLES = 500
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cmd_valid_i,
   output logic          cmd_ready_o,
   input  logic          cmd_mode_i,
   input  logic [AW-1:0] cmd_addr_i,
   input  logic [DW-1:0] cmd_data_i,
   output logic          bus_req_o,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   input  logic          bus_ack_i,
   input  logic [DW-1:0] bus_rdata_i,
   output logic          fin_o,
   output logic [1:0]    fin_code_o
);
   initial begin : param_chk
      assert (DP_BIT < DW && TG_BIT < DW && DP_BIT != TG_BIT &&
              MAX_POLLS >= 2 && GAP_CYCLES >= 1 && AW >= 1)
         else $fatal(1, "pdp_poller: parameter set out of range");
   end

   logic [DW-1:0] sav_data;
   logic prev_tg, have_prev, dp_hit, tg_hit, byte_ok;
   logic poll_last, poll_clr, poll_inc, gap_last, gap_clr, gap_inc;

   pdp_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk_i, .rst_ni, .cmd_valid_i, .cmd_mode_i, .cmd_addr_i, .cmd_data_i,
      .cmd_ready_o, .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o, .bus_ack_i,
      .rd_tg_i     (bus_rdata_i[TG_BIT]),
      .dp_hit_i    (dp_hit),
      .tg_hit_i    (tg_hit),
      .byte_ok_i   (byte_ok),
      .sav_data_o  (sav_data),
      .prev_tg_o   (prev_tg),
      .have_prev_o (have_prev),
      .poll_last_i (poll_last),
      .poll_clr_o  (poll_clr),
      .poll_inc_o  (poll_inc),
      .gap_last_i  (gap_last),
      .gap_clr_o   (gap_clr),
      .gap_inc_o   (gap_inc),
      .fin_o, .fin_code_o
   );

   pdp_judge #(.DW(DW), .DP_BIT(DP_BIT), .TG_BIT(TG_BIT)) u_judge (
      .rdata_i     (bus_rdata_i),
      .sav_data_i  (sav_data),
      .prev_tg_i   (prev_tg),
      .have_prev_i (have_prev),
      .dp_hit_o    (dp_hit),
      .tg_hit_o    (tg_hit),
      .byte_ok_o   (byte_ok)
   );

   pdp_limit_cnt #(.LIMIT(MAX_POLLS)) u_poll_cnt (
      .clk_i, .rst_ni, .clr_i(poll_clr), .inc_i(poll_inc), .at_last_o(poll_last)
   );

   pdp_limit_cnt #(.LIMIT(GAP_CYCLES)) u_gap_cnt (
      .clk_i, .rst_ni, .clr_i(gap_clr), .inc_i(gap_inc), .at_last_o(gap_last)
   );
endmodule

// File: rtl/pdp_poller_chk.sv
module pdp_poller_chk #(
   parameter int AW         = 15,
   parameter int DW         = 8,
   parameter int MAX_POLLS  = 4096,
   parameter int GAP_CYCLES = 500
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          cmd_valid_i,
   input logic          cmd_ready_o,
   input logic [AW-1:0] cmd_addr_i,
   input logic [DW-1:0] cmd_data_i,
   input logic          bus_req_o,
   input logic          bus_we_o,
   input logic [AW-1:0] bus_addr_o,
   input logic [DW-1:0] bus_wdata_o,
   input logic          bus_ack_i,
   input logic          fin_o,
   input logic [1:0]    fin_code_o
);
   localparam int GW = $clog2(GAP_CYCLES + 1);

   logic [AW-1:0] cap_addr;
   logic [DW-1:0] cap_data;
   int unsigned   rd_cnt;
   logic [GW-1:0] gap_left;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cap_addr <= '0;
         cap_data <= '0;
         rd_cnt   <= 0;
         gap_left <= '0;
      end else begin
         if (cmd_valid_i && cmd_ready_o) begin
            cap_addr <= cmd_addr_i;
            cap_data <= cmd_data_i;
            rd_cnt   <= 0;
         end else if (bus_req_o && !bus_we_o && bus_ack_i) begin
            rd_cnt <= rd_cnt + 1;
         end
         if (fin_o)               gap_left <= GW'(GAP_CYCLES - 1);
         else if (gap_left != '0) gap_left <= gap_left - 1'b1;
      end
   end

   a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                  $stable(bus_we_o) && $stable(bus_wdata_o));
   a_r8_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_o && bus_ack_i |=> !bus_req_o);
   a_r7_fin_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fin_o |=> !fin_o);
   a_r7_fin_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fin_o |-> !cmd_ready_o);
   a_r7_gap_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gap_left != '0 |-> !cmd_ready_o && !bus_req_o);
   a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_ready_o |-> !bus_req_o && !fin_o);
   a_r2_addr_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_o |-> bus_addr_o == cap_addr);
   a_r2_wdata_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_o && bus_we_o |-> bus_wdata_o == cap_data);
   a_r6_read_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_cnt <= MAX_POLLS + 1);
   a_r6_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fin_o |-> fin_code_o != 2'd3);
endmodule

bind pdp_poller pdp_poller_chk #(
   .AW(AW), .DW(DW), .MAX_POLLS(MAX_POLLS), .GAP_CYCLES(GAP_CYCLES)
) u_chk (
   .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_addr_i, .cmd_data_i,
   .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o, .bus_ack_i,
   .fin_o, .fin_code_o
);

// File: tb/pdp_poller_bench.sv
module pdp_poller_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 15;
   localparam int DW   = 8;
   localparam int MAXP = 6;
   localparam int GAP  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0, cmd_mode = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic          cmd_ready, bus_req, bus_we, fin;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_ack = 1'b0;
   logic [DW-1:0] bus_rdata = '0;
   logic [1:0]    fin_code;

   int errs = 0, checks = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pdp_poller #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP), .GAP_CYCLES(GAP)) u_pdp_poller (
      .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
      .cmd_mode_i(cmd_mode), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
      .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
      .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
      .fin_o(fin), .fin_code_o(fin_code)
   );

   // memory model
   int m_busy = 0, m_lat = 0, m_wait = 0, m_left = 0;
   logic m_t0 = 1'b0, m_tog = 1'b0, m_corrupt = 1'b0;
   logic [DW-1:0] m_byte = '0;
   logic [AW-1:0] m_waddr = '0;
   int m_writes = 0, m_reads = 0, m_badaddr = 0, m_r8bad = 0, fin_cnt = 0;

   always @(negedge clk) begin
      if (fin) fin_cnt++;
      if (bus_ack) begin
         bus_ack = 1'b0;
         if (bus_req) m_r8bad++;
      end else if (bus_req) begin
         if (m_wait >= m_lat) begin
            m_wait = 0;
            bus_ack = 1'b1;
            if (bus_we) begin
               m_writes++;
               m_byte  = bus_wdata;
               m_waddr = bus_addr;
               m_left  = m_busy;
               m_tog   = m_t0;
               bus_rdata = '0;
            end else begin
               m_reads++;
               if (bus_addr != m_waddr || m_writes == 0) m_badaddr++;
               if (m_left > 0) begin
                  bus_rdata = {~m_byte[7], m_tog, m_byte[5:0]};
                  m_tog = ~m_tog;
                  m_left--;
               end else begin
                  bus_rdata = m_corrupt ? (m_byte ^ 8'h01) : m_byte;
               end
            end
         end else begin
            m_wait++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic tg_of(input int k, input int n, input logic t0, input logic [DW-1:0] d);
      if (k <= n) return t0 ^ logic'((k - 1) % 2);
      return d[6];
   endfunction

   task automatic run_one(input logic mode, input int n, input logic t0,
                          input logic [DW-1:0] d, input logic bad, input int lat,
                          input logic [AW-1:0] addr);
      int exp_reads, exp_code, w, gap;
      int code;
      string rtag;
      if (mode == 1'b0) begin
         if (n + 1 > MAXP) begin exp_reads = MAXP; exp_code = 2; end
         else begin exp_reads = n + 2; exp_code = bad ? 1 : 0; end
         rtag = (exp_code == 2) ? "R6" : "R3";
      end else begin
         exp_reads = MAXP; exp_code = 2;
         for (int k = 2; k <= MAXP; k++) begin
            if (tg_of(k, n, t0, d) == tg_of(k - 1, n, t0, d)) begin
               exp_reads = k; exp_code = 0; break;
            end
         end
         rtag = (exp_code == 2) ? "R6" : "R5";
      end
      m_busy = n; m_t0 = t0; m_corrupt = bad; m_lat = lat; m_wait = 0;
      m_writes = 0; m_reads = 0; m_badaddr = 0; m_r8bad = 0; fin_cnt = 0;
      w = 0;
      while (!cmd_ready && w < 100) begin @(negedge clk); w++; end
      cmd_valid = 1'b1; cmd_mode = mode; cmd_addr = addr; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      w = 0;
      while (!fin && w < 2000) begin @(negedge clk); w++; end
      chk(fin == 1'b1, "R7 fin seen", int'(fin), 1);
      code = int'(fin_code);
      // R9: command offered during hold-off must be ignored
      cmd_valid = 1'b1; cmd_addr = ~addr; cmd_data = ~d;
      gap = 0;
      do begin
         @(negedge clk);
         cmd_valid = 1'b0;
         gap++;
      end while (!cmd_ready && gap < 100);
      chk(m_writes == 1, "R2 write count", m_writes, 1);
      chk(m_waddr == addr, "R2 write addr", int'(m_waddr), int'(addr));
      chk(m_byte == (bad ? m_byte : d) && m_byte == d, "R9/R2 stored byte", int'(m_byte), int'(d));
      chk(m_reads == exp_reads, rtag, m_reads, exp_reads);
      chk(m_badaddr == 0, "R3 poll address", m_badaddr, 0);
      chk(code == exp_code, (exp_code == 1 || mode == 1'b0) ? "R4 code" : "R5 code", code, exp_code);
      chk(fin_cnt == 1, "R7 fin pulses", fin_cnt, 1);
      chk(gap == GAP, "R7 hold-off", gap, GAP);
      chk(m_r8bad == 0, "R8 req drop", m_r8bad, 0);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [DW-1:0] pats [4];
      int idx;
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A; pats[3] = 8'hA5;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
      chk(bus_req == 1'b0, "R1 req", int'(bus_req), 0);
      chk(fin == 1'b0, "R1 fin", int'(fin), 0);
      idx = 0;
      for (int mode = 0; mode < 2; mode++)
         for (int n = 0; n <= MAXP + 1; n++)
            for (int t = 0; t < 2; t++)
               for (int p = 0; p < 4; p++) begin
                  run_one(logic'(mode), n, logic'(t), pats[p], 1'b0, idx % 3,
                          AW'(15'h1234 + idx * 37));
                  idx++;
               end
      // R4 verify error: low bit goes bad after programming
      for (int n = 0; n <= MAXP; n++)
         for (int p = 0; p < 4; p++) begin
            run_one(1'b0, n, 1'b0, pats[p], 1'b1, (n + p) % 3, AW'(15'h2A00 + n * 5 + p));
         end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule